// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block keeps, for each entry of a memory-protection table, a mode and a word-granular address register, and turns them into an inclusive start and end byte address that a permission checker can compare against. The address register holds a byte address divided by four. Four modes are supported: disabled, top-of-range (the region runs from the previous entry's address up to, but not including, this entry's address), a naturally aligned four-byte region, and a naturally aligned power-of-two region whose size comes from the run of low one bits in the address register.

Writes arrive on a single write port that can update an entry's mode, its address, or both in one cycle. The bounds of each entry sit in registers that are refreshed on the clock edge that takes the write. A top-of-range entry also depends on its lower neighbour's address, so an address write to one entry refreshes the entry above it when that entry is in top-of-range mode. Between writes the bounds hold, so the checker sees a plain register compare.

Top module: `pmp_bounds_decoder`

## Requirements
- R1: After reset every entry is disabled with address 0, and every entry's bounds read start 0 and end all ones.
- R2: Mode code 0 (disabled) gives start 0 and end all ones, whatever the address register holds.
- R3: Mode code 1 (top-of-range) gives start = previous entry's address times four and end = this entry's address times four minus one, modulo 2^(AW+2), so address 0 gives an end of all ones.
- R4: For entry 0 in top-of-range mode the previous address is taken as zero.
- R5: Mode code 2 (four-byte) gives start = address times four and end = start + 3.
- R6: Mode code 3 (power-of-two) with t trailing one bits in the address gives start = address with its low t bits cleared, times four, and end = start + 2^(t+3) - 1.
- R7: Mode code 3 with an all-ones address gives start 0 and end all ones.
- R8: An entry's bounds change on the clock edge that accepts a write to that entry and are visible from that edge on; with no write, no bounds change.
- R9: An address write to entry i also refreshes entry i+1 when entry i+1 is (after that write) in top-of-range mode, so its start follows the new address at the same edge.
- R10: An address write to entry i leaves entry i+1 unchanged when entry i+1 is not in top-of-range mode.
- R11: A mode write and an address write to the same entry in the same cycle decode from both new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write the mode of entry `wr_index` |
| addr_we | input | 1 | Write the address register of entry `wr_index` |
| wr_index | input | IW | Entry targeted by the write |
| cfg_mode_in | input | 2 | Mode code: 0 disabled, 1 top-of-range, 2 four-byte, 3 power-of-two |
| addr_in | input | AW | Address register value (byte address divided by four) |
| lo_flat | output | ENTRIES*(AW+2) | Start byte address of every entry, entry e at bits [e*(AW+2) +: AW+2] |
| hi_flat | output | ENTRIES*(AW+2) | Inclusive end byte address of every entry, same packing |

## Verification
A stale or wrong stored mode or address shows up on the bounds outputs at the very edge that takes the next write to that entry, because the bounds register is loaded from the next-state values of the same cycle. A missed neighbour refresh leaves a top-of-range entry's start pointing at its lower neighbour's old address, which the bench exposes by sweeping the lower neighbour's address and comparing every entry after every write. Sweeps cover every address value in the four-byte, power-of-two and entry-0 top-of-range modes, so off-by-one errors in the trailing-ones count or the wrap of the top-of-range end appear within one write.

// File: rtl/pmp_bd_pkg.sv
`timescale 1ns/1ps
// Shared types for the protection region bounds decoder.
// Assumes the mode code is two bits wide and its values are fixed by the
// permission checker that consumes the bounds.
package pmp_bd_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } region_mode_e;
endpackage

// File: rtl/pmp_trail_ones.sv
`timescale 1ns/1ps
// Counts the run of one bits at the low end of a vector.
// Implemented as a priority encoder on the inverted vector: the lowest
// zero bit gives the count. Assumes W >= 1; an all-ones vector reports W
// and raises all_set.
module pmp_trail_ones #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count,
    output logic          all_set
);
    // Lowest zero bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        count = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!vec[i]) count = CW'(i);
        end
    end

    // Flag the special all-ones pattern.
    assign all_set = &vec;
endmodule

// File: rtl/pmp_range_calc.sv
`timescale 1ns/1ps
// Combinational decode of one entry's mode and address register (plus the
// lower neighbour's address) into inclusive start/end byte addresses.
// Assumes addresses are word granular (byte address >> 2) and that byte
// arithmetic wraps modulo 2^(AW+2).
module pmp_range_calc
    import pmp_bd_pkg::*;
#(
    parameter int AW = 8,
    parameter int BW = AW + 2
) (
    input  region_mode_e  mode,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] prev_addr,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi
);
    localparam int CW = $clog2(AW + 1);

    logic [CW-1:0] ones_cnt;
    logic          ones_all;
    logic [BW-1:0] cur_byte;
    logic [BW-1:0] prev_byte;
    logic [BW-1:0] napot_mask;

    pmp_trail_ones #(.W(AW), .CW(CW)) u_tones (
        .vec     (cur_addr),
        .count   (ones_cnt),
        .all_set (ones_all)
    );

    assign cur_byte  = {cur_addr, 2'b00};
    assign prev_byte = {prev_addr, 2'b00};

    // Low (t+3) byte-address bits form the offset within a power-of-two region.
    always_comb begin
        for (int b = 0; b < BW; b++) begin
            napot_mask[b] = (b < (int'(ones_cnt) + 3));
        end
    end

    // Select the bounds for the entry's mode.
    always_comb begin
        unique case (mode)
            MODE_TOR: begin
                lo = prev_byte;
                hi = cur_byte - BW'(1);
            end
            MODE_NA4: begin
                lo = cur_byte;
                hi = cur_byte | BW'(3);
            end
            MODE_NAPOT: begin
                if (ones_all) begin
                    lo = '0;
                    hi = '1;
                end else begin
                    lo = cur_byte & ~napot_mask;
                    hi = (cur_byte & ~napot_mask) | napot_mask;
                end
            end
            default: begin
                lo = '0;
                hi = '1;
            end
        endcase
    end
endmodule

// File: rtl/pmp_bound_slot.sv
`timescale 1ns/1ps
// One entry's bounds register. Loads the decoded range when refresh is
// high and holds it otherwise. Assumes the inputs are the entry's
// next-state mode and addresses, so the register matches them after the edge.
module pmp_bound_slot
    import pmp_bd_pkg::*;
#(
    parameter int AW = 8,
    parameter int BW = AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          refresh,
    input  region_mode_e  mode,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] prev_addr,
    output logic [BW-1:0] lo_q,
    output logic [BW-1:0] hi_q
);
    logic [BW-1:0] lo_d;
    logic [BW-1:0] hi_d;

    pmp_range_calc #(.AW(AW), .BW(BW)) u_calc (
        .mode      (mode),
        .cur_addr  (cur_addr),
        .prev_addr (prev_addr),
        .lo        (lo_d),
        .hi        (hi_d)
    );

    // Capture new bounds on refresh; reset to the disabled full range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '1;
        end else if (refresh) begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end
endmodule

// File: rtl/pmp_bounds_decoder.sv
`timescale 1ns/1ps
// Protection region bounds decoder: holds per-entry mode and address
// registers and a registered start/end pair per entry. A write refreshes
// the written entry and, for an address write, the entry above it when
// that entry is top-of-range. Assumes one write index per cycle.
module pmp_bounds_decoder
    import pmp_bd_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 8,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int BW     = AW + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  addr_we,
    input  logic [IW-1:0]         wr_index,
    input  logic [1:0]            cfg_mode_in,
    input  logic [AW-1:0]         addr_in,
    output logic [ENTRIES*BW-1:0] lo_flat,
    output logic [ENTRIES*BW-1:0] hi_flat
);
    region_mode_e        mode_q  [ENTRIES];
    region_mode_e        mode_d  [ENTRIES];
    logic [AW-1:0]       addr_q  [ENTRIES];
    logic [AW-1:0]       addr_d  [ENTRIES];
    logic [ENTRIES-1:0]  refresh;

    // Next-state mode and address for every entry after this cycle's write.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            mode_d[e] = mode_q[e];
            addr_d[e] = addr_q[e];
            if (cfg_we && (wr_index == IW'(e))) mode_d[e] = region_mode_e'(cfg_mode_in);
            if (addr_we && (wr_index == IW'(e))) addr_d[e] = addr_in;
        end
    end

    // Which bounds registers reload: the written entry and a dependent TOR neighbour.
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            refresh[e] = (cfg_we || addr_we) && (wr_index == IW'(e));
            if (e > 0) begin
                if (addr_we && (wr_index == IW'(e - 1)) && (mode_d[e] == MODE_TOR))
                    refresh[e] = 1'b1;
            end
        end
    end

    // Mode and address storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mode_q[e] <= MODE_OFF;
                addr_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                mode_q[e] <= mode_d[e];
                addr_q[e] <= addr_d[e];
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [AW-1:0] prev_addr;
        if (g == 0) begin : g_first
            assign prev_addr = '0;
        end else begin : g_rest
            assign prev_addr = addr_d[g-1];
        end

        pmp_bound_slot #(.AW(AW), .BW(BW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .refresh   (refresh[g]),
            .mode      (mode_d[g]),
            .cur_addr  (addr_d[g]),
            .prev_addr (prev_addr),
            .lo_q      (lo_flat[g*BW +: BW]),
            .hi_q      (hi_flat[g*BW +: BW])
        );
    end
endmodule

// File: rtl/pmp_bounds_decoder_chk.sv
`timescale 1ns/1ps
// Assertion checker for pmp_bounds_decoder, attached by bind. It records
// the last write and checks the written entry's bounds one edge later.
module pmp_bounds_decoder_chk
    import pmp_bd_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 8,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int BW     = AW + 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic                  addr_we,
    input logic [IW-1:0]         wr_index,
    input logic [1:0]            cfg_mode_in,
    input logic [AW-1:0]         addr_in,
    input logic [ENTRIES*BW-1:0] lo_flat,
    input logic [ENTRIES*BW-1:0] hi_flat
);
    logic          cfg_seen;
    logic          addr_seen;
    logic [IW-1:0] idx_seen;
    region_mode_e  mode_seen;
    logic [AW-1:0] addr_val;
    logic [BW-1:0] sel_lo;
    logic [BW-1:0] sel_hi;
    logic [BW-1:0] span;

    // Remember the previous cycle's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_seen  <= 1'b0;
            addr_seen <= 1'b0;
            idx_seen  <= '0;
            mode_seen <= MODE_OFF;
            addr_val  <= '0;
        end else begin
            cfg_seen  <= cfg_we;
            addr_seen <= addr_we;
            idx_seen  <= wr_index;
            mode_seen <= region_mode_e'(cfg_mode_in);
            addr_val  <= addr_in;
        end
    end

    assign sel_lo = lo_flat[int'(idx_seen)*BW +: BW];
    assign sel_hi = hi_flat[int'(idx_seen)*BW +: BW];
    assign span   = sel_hi - sel_lo;

    assert_off_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_seen && mode_seen == MODE_OFF) |-> (sel_lo == '0 && sel_hi == '1));

    assert_tor_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_seen && addr_seen && mode_seen == MODE_TOR) |-> (sel_hi == ({addr_val, 2'b00} - BW'(1))));

    assert_na4_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_seen && mode_seen == MODE_NA4) |-> (span == BW'(3)));

    assert_napot_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_seen && mode_seen == MODE_NAPOT) |-> (((span & (span + BW'(1))) == '0) && ((sel_lo & span) == '0)));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !addr_we) |=> ($stable(lo_flat) && $stable(hi_flat)));
endmodule

bind pmp_bounds_decoder pmp_bounds_decoder_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .addr_we     (addr_we),
    .wr_index    (wr_index),
    .cfg_mode_in (cfg_mode_in),
    .addr_in     (addr_in),
    .lo_flat     (lo_flat),
    .hi_flat     (hi_flat)
);

// File: tb/pmp_bounds_decoder_tb.sv
`timescale 1ns/1ps
module pmp_bounds_decoder_tb;
    localparam int ENTRIES = 4;
    localparam int AW      = 8;
    localparam int IW      = 2;
    localparam int BW      = AW + 2;
    localparam int AMAX    = (1 << AW) - 1;
    localparam int BMASK   = (1 << BW) - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cfg_we = 1'b0;
    logic                  addr_we = 1'b0;
    logic [IW-1:0]         wr_index = '0;
    logic [1:0]            cfg_mode_in = 2'd0;
    logic [AW-1:0]         addr_in = '0;
    logic [ENTRIES*BW-1:0] lo_flat;
    logic [ENTRIES*BW-1:0] hi_flat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int m_mode [ENTRIES];
    int m_addr [ENTRIES];

    always #4 clk = ~clk;

    pmp_bounds_decoder #(.ENTRIES(ENTRIES), .AW(AW)) u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .addr_we (addr_we),
        .wr_index (wr_index), .cfg_mode_in (cfg_mode_in), .addr_in (addr_in),
        .lo_flat (lo_flat), .hi_flat (hi_flat)
    );

    // Expected bounds from the requirements, in plain integer arithmetic.
    function automatic void expect_bounds(input int e, output int lo, output int hi, output string req);
        int cur, prv, t;
        cur = m_addr[e];
        prv = (e == 0) ? 0 : m_addr[e-1];
        case (m_mode[e])
            1: begin lo = prv * 4; hi = (cur * 4 - 1) & BMASK; req = (e == 0) ? "R4" : "R3"; end
            2: begin lo = cur * 4; hi = cur * 4 + 3; req = "R5"; end
            3: begin
                if (cur == AMAX) begin lo = 0; hi = BMASK; req = "R7"; end
                else begin
                    t = 0;
                    while (((cur >> t) & 1) == 1) t++;
                    lo = ((cur >> t) << t) * 4;
                    hi = lo + (1 << (t + 3)) - 1;
                    req = "R6";
                end
            end
            default: begin lo = 0; hi = BMASK; req = "R2"; end
        endcase
    endfunction

    task automatic check_all(input string ctx);
        int elo, ehi, alo, ahi;
        string req;
        for (int e = 0; e < ENTRIES; e++) begin
            expect_bounds(e, elo, ehi, req);
            alo = int'(lo_flat[e*BW +: BW]);
            ahi = int'(hi_flat[e*BW +: BW]);
            checks++;
            if (alo != elo || ahi != ehi) begin
                failures++;
                $display("FAIL %s/%s entry %0d lo=%0h hi=%0h expected lo=%0h hi=%0h",
                         ctx, req, e, alo, ahi, elo, ehi);
            end
        end
    endtask

    // Drive one write at a falling edge; the model follows; return after the next falling edge.
    task automatic do_write(input bit wc, input bit wa, input int idx, input int mode, input int addr);
        @(negedge clk);
        cfg_we      = wc;
        addr_we     = wa;
        wr_index    = IW'(idx);
        cfg_mode_in = 2'(mode);
        addr_in     = AW'(addr);
        if (wc) m_mode[idx] = mode;
        if (wa) m_addr[idx] = addr;
        @(negedge clk);
        cfg_we  = 1'b0;
        addr_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < ENTRIES; e++) begin m_mode[e] = 0; m_addr[e] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R6 R7: every address in power-of-two mode on entry 2.
        do_write(1, 0, 2, 3, 0);
        check_all("R8");
        for (int a = 0; a <= AMAX; a++) begin do_write(0, 1, 2, 0, a); check_all("R8"); end

        // R5: every address in four-byte mode on entry 1.
        do_write(1, 0, 1, 2, 0);
        for (int a = 0; a <= AMAX; a++) begin do_write(0, 1, 1, 0, a); check_all("R8"); end

        // R3 R4: entry 0 top-of-range, including address 0 wrap.
        do_write(1, 0, 0, 1, 0);
        for (int a = 0; a <= AMAX; a++) begin do_write(0, 1, 0, 0, a); check_all("R4"); end

        // R9: entry 3 top-of-range follows entry 2's address writes.
        do_write(1, 1, 3, 1, 200);
        for (int a = 0; a <= AMAX; a += 3) begin do_write(0, 1, 2, 0, a); check_all("R9"); end

        // R10: entry 2 is power-of-two, unaffected by entry 1 address writes.
        do_write(0, 1, 2, 0, 8'h17);
        for (int a = 0; a <= AMAX; a += 17) begin do_write(0, 1, 1, 0, a); check_all("R10"); end

        // R11: mode and address written together.
        do_write(1, 1, 1, 1, 77);
        check_all("R11");
        do_write(1, 1, 2, 2, 250);
        check_all("R11");
        do_write(1, 1, 2, 3, 8'h3f);
        check_all("R11");

        // R2: disabled mode ignores the address.
        do_write(1, 0, 2, 0, 0);
        check_all("R2");
        for (int a = 0; a <= AMAX; a += 51) begin do_write(0, 1, 2, 0, a); check_all("R2"); end

        // R8: idle cycles leave every bound as it was.
        repeat (6) @(negedge clk);
        check_all("R8");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule